// File: doc/BRIEF.md
# Four-Way Write-Through Unified Cache

This block is a unified cache of 8 KB for instruction fetches and data accesses alike. It sits between a processor-side request port and a memory-side port. The processor side issues one 32-bit word read or write at a time with a valid/ready handshake, and receives a one-cycle response pulse. The memory side accepts either a line read or a single-word write through its own valid/ready handshake. For a line read, it returns the four words of the line as separate beats.

The storage is organised as 128 sets of four ways, and each line holds four 32-bit words. Each way keeps its tag and valid bit in a store separate from the data words. A read that misses brings in the whole line before it answers. Every write is forwarded to memory. A write that hits also updates the cached word, and a write that misses leaves the cache untouched. On a fill, the victim is the lowest-numbered invalid way. When all four ways are valid, the victim is the least recently used way, tracked with a per-set age order. A flush input drops every line at once.

Top module: `wt_cache4`

## Requirements
- R1: The address is split as word select = bits [3:2], set index = bits [10:4] and tag = bits [31:11]. This gives 128 sets, 4 ways and 4 words per line. Two addresses that differ only in the tag occupy different ways of the same set.
- R2: A read hit raises `cpu_rsp_valid` for exactly one cycle, in the cycle after the request is accepted. The pulse carries the cached word and causes no memory request.
- R3: A read miss issues one memory request with `mem_req_we` = 0 and the address with bits [3:0] cleared. Memory returns words 0 to 3 of the line in order. After the fourth beat, the response follows in the next cycle with the requested word. Later reads of any word of that line then hit.
- R4: Every write issues exactly one memory request with `mem_req_we` = 1 and the CPU's address and data. This request appears two cycles after the CPU write is accepted. The CPU response pulse occurs in the cycle the memory accepts it.
- R5: A write hit replaces the cached word, and a later read hit returns the new value.
- R6: A write miss fetches no line. A later read of the same address misses.
- R7: On a fill, a way whose valid bit is clear is used before any valid way is replaced. After a flush, four different tags in one set are all resident.
- R8: When all four ways of a set are valid, a fill replaces the way used least recently. Read hits, write hits and fills all count as uses.
- R9: A cycle with `flush` high clears every valid bit, so the next read of any address misses.
- R10: A memory request keeps `mem_req_valid`, `mem_req_we` and `mem_req_addr` stable until `mem_req_ready` is high.
- R11: After reset no line is valid, `cpu_req_ready` is 1, and `mem_req_valid` and `cpu_rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all lines |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Byte address of the word |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | 32 | Read data, meaningful for reads |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = single-word write, 0 = line read |
| mem_req_addr | output | 32 | Word address (write) or line address (read) |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Line-read beat present |
| mem_rsp_rdata | input | 32 | Line-read beat data |

## Verification
The hardest case to reach is an eviction where recency order decides the victim. That needs five distinct tags mapping to one set, with a hit in between that reorders the ages, so the stimulus builds addresses that share bits [10:4] and differ above bit 10. A second phase drives a long pseudo-random mix of reads and writes over three sets and six tags. Memory stalls and gaps between beats vary throughout, and a behavioural model with per-set recency queues predicts every hit and miss. Flushes are placed between full sets so that refills fall on invalid ways.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned BYTE_W = $clog2(DATA_W / 8);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WRITE,
        ST_FILL_REQ,
        ST_FILL_DATA,
        ST_RESPOND
    } state_e;

    typedef struct packed {
        logic  we;
        addr_t addr;
        word_t wdata;
    } cpu_req_t;

    // Clear the low 'ofs' bits of an address (line base).
    function automatic addr_t align_down(addr_t a, int unsigned ofs);
        return (a >> ofs) << ofs;
    endfunction
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store
    import wtc_pkg::*;
#(
    parameter int unsigned SETS  = 128,
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 21,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic [WAYS-1:0]  hit_vec_o,
    output logic [WAYS-1:0]  valid_vec_o,
    input  logic [WAY_W-1:0] upd_way_i,
    input  logic             inv_en_i,
    input  logic             fill_en_i
);
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
            end
        end else if (fill_en_i) begin
            vld_q[idx_i][upd_way_i] <= 1'b1;
        end else if (inv_en_i) begin
            vld_q[idx_i][upd_way_i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en_i) begin
            tag_q[idx_i][upd_way_i] <= tag_i;
        end
    end

    assign valid_vec_o = vld_q[idx_i];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec_o[w] = vld_q[idx_i][w] && (tag_q[idx_i][w] == tag_i);
    end
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store
    import wtc_pkg::*;
#(
    parameter int unsigned SETS  = 128,
    parameter int unsigned WAYS  = 4,
    parameter int unsigned WORDS = 4,
    localparam int unsigned IDX_W  = $clog2(SETS),
    localparam int unsigned WAY_W  = $clog2(WAYS),
    localparam int unsigned WORD_W = $clog2(WORDS),
    localparam int unsigned LOC_W  = IDX_W + WAY_W + WORD_W,
    localparam int unsigned DEPTH  = SETS * WAYS * WORDS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              we_i,
    input  logic [WAY_W-1:0]  wr_way_i,
    input  logic [WORD_W-1:0] wr_word_i,
    input  word_t             wr_data_i,
    input  logic [WAY_W-1:0]  rd_way_i,
    input  logic [WORD_W-1:0] rd_word_i,
    output word_t             rd_data_o
);
    word_t mem_q [DEPTH];

    logic [LOC_W-1:0] wr_loc, rd_loc;
    assign wr_loc = {idx_i, wr_way_i, wr_word_i};
    assign rd_loc = {idx_i, rd_way_i, rd_word_i};

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[wr_loc] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_loc];
endmodule

// File: rtl/wtc_lru.sv
module wtc_lru
    import wtc_pkg::*;
#(
    parameter int unsigned SETS = 128,
    parameter int unsigned WAYS = 4,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             touch_en_i,
    input  logic [WAY_W-1:0] touch_way_i,
    input  logic [WAYS-1:0]  valid_vec_i,
    output logic [WAY_W-1:0] victim_o
);
    // Age 0 = most recently used, age WAYS-1 = least recently used.
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] touch_age;

    assign touch_age = age_q[idx_i][touch_way_i];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en_i) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way_i) begin
                    age_q[idx_i][w] <= '0;
                end else if (age_q[idx_i][w] < touch_age) begin
                    age_q[idx_i][w] <= age_q[idx_i][w] + 1'b1;
                end
            end
        end
    end

    logic any_invalid;
    always_comb begin
        victim_o    = '0;
        any_invalid = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec_i[w]) begin
                victim_o    = WAY_W'(w);
                any_invalid = 1'b1;
            end
        end
        if (!any_invalid) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[idx_i][w] == WAY_W'(WAYS - 1)) begin
                    victim_o = WAY_W'(w);
                end
            end
        end
    end
endmodule

// File: rtl/wt_cache4.sv
module wt_cache4
    import wtc_pkg::*;
#(
    parameter int unsigned SETS  = 128,
    parameter int unsigned WAYS  = 4,
    parameter int unsigned WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);
    localparam int unsigned WORD_W = $clog2(WORDS);
    localparam int unsigned OFS_W  = WORD_W + BYTE_W;
    localparam int unsigned IDX_W  = $clog2(SETS);
    localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFS_W;
    localparam int unsigned WAY_W  = $clog2(WAYS);

    state_e            state_q, state_d;
    cpu_req_t          req_q;
    logic [WAY_W-1:0]  vict_q;
    logic [WORD_W-1:0] beat_q;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WORD_W-1:0] req_word;
    assign req_idx  = req_q.addr[OFS_W +: IDX_W];
    assign req_tag  = req_q.addr[ADDR_W-1 -: TAG_W];
    assign req_word = req_q.addr[BYTE_W +: WORD_W];

    logic [WAYS-1:0]  hit_vec, valid_vec;
    logic             hit_any;
    logic [WAY_W-1:0] hit_way, victim;
    logic             last_beat;

    assign hit_any   = |hit_vec;
    assign last_beat = (beat_q == WORD_W'(WORDS - 1));

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    // Datapath control derived from the current state
    logic             inv_en, fill_en, touch_en, dwe;
    logic [WAY_W-1:0] touch_way, wr_way, rd_way;
    logic [WORD_W-1:0] wr_word;
    word_t            wr_data;

    always_comb begin
        inv_en    = (state_q == ST_FILL_REQ) && mem_req_ready;
        fill_en   = (state_q == ST_FILL_DATA) && mem_rsp_valid && last_beat;
        touch_en  = ((state_q == ST_LOOKUP) && hit_any) || (state_q == ST_RESPOND);
        touch_way = (state_q == ST_RESPOND) ? vict_q : hit_way;
        rd_way    = (state_q == ST_RESPOND) ? vict_q : hit_way;
        dwe       = 1'b0;
        wr_way    = vict_q;
        wr_word   = beat_q;
        wr_data   = mem_rsp_rdata;
        if ((state_q == ST_LOOKUP) && req_q.we && hit_any) begin
            dwe     = 1'b1;
            wr_way  = hit_way;
            wr_word = req_word;
            wr_data = req_q.wdata;
        end else if ((state_q == ST_FILL_DATA) && mem_rsp_valid) begin
            dwe = 1'b1;
        end
    end

    // Port outputs
    assign cpu_req_ready = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_WRITE) || (state_q == ST_FILL_REQ);
    assign mem_req_we    = (state_q == ST_WRITE);
    assign mem_req_addr  = (state_q == ST_WRITE) ? req_q.addr : align_down(req_q.addr, OFS_W);
    assign mem_req_wdata = req_q.wdata;
    assign cpu_rsp_valid = ((state_q == ST_LOOKUP) && !req_q.we && hit_any)
                         || ((state_q == ST_WRITE) && mem_req_ready)
                         || (state_q == ST_RESPOND);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cpu_req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (req_q.we)     state_d = ST_WRITE;
                else if (hit_any) state_d = ST_IDLE;
                else              state_d = ST_FILL_REQ;
            end
            ST_WRITE:     if (mem_req_ready) state_d = ST_IDLE;
            ST_FILL_REQ:  if (mem_req_ready) state_d = ST_FILL_DATA;
            ST_FILL_DATA: if (mem_rsp_valid && last_beat) state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            vict_q  <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req_valid) begin
                req_q <= '{we: cpu_req_we, addr: cpu_req_addr, wdata: cpu_req_wdata};
            end
            if (state_q == ST_LOOKUP) begin
                vict_q <= victim;
            end
            if (state_q == ST_FILL_REQ) begin
                beat_q <= '0;
            end else if (state_q == ST_FILL_DATA && mem_rsp_valid) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    wtc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (flush),
        .idx_i       (req_idx),
        .tag_i       (req_tag),
        .hit_vec_o   (hit_vec),
        .valid_vec_o (valid_vec),
        .upd_way_i   (vict_q),
        .inv_en_i    (inv_en),
        .fill_en_i   (fill_en)
    );

    wtc_data_store #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS)) u_data (
        .clk       (clk),
        .idx_i     (req_idx),
        .we_i      (dwe),
        .wr_way_i  (wr_way),
        .wr_word_i (wr_word),
        .wr_data_i (wr_data),
        .rd_way_i  (rd_way),
        .rd_word_i (req_word),
        .rd_data_o (cpu_rsp_rdata)
    );

    wtc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk         (clk),
        .rst         (rst),
        .idx_i       (req_idx),
        .touch_en_i  (touch_en),
        .touch_way_i (touch_way),
        .valid_vec_i (valid_vec),
        .victim_o    (victim)
    );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker
    import wtc_pkg::*;
#(
    parameter int unsigned OFS_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_req_we,
    input logic [ADDR_W-1:0] cpu_req_addr,
    input logic [DATA_W-1:0] cpu_req_wdata,
    input logic              cpu_rsp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata
);
    // While able to accept, the block is quiet on both sides.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        cpu_req_ready |-> (!mem_req_valid && !cpu_rsp_valid));

    // A response is a single-cycle pulse followed by readiness.
    p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_rsp_valid |=> (!cpu_rsp_valid && cpu_req_ready));

    // Memory request stays put until taken.
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

    // Line reads are line aligned.
    p_fill_align_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_we) |-> (mem_req_addr[OFS_W-1:0] == '0));

    // Every accepted write reaches memory two cycles later.
    p_write_through_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_req_ready && cpu_req_we) |-> ##2
            (mem_req_valid && mem_req_we
             && mem_req_addr == $past(cpu_req_addr, 2)
             && mem_req_wdata == $past(cpu_req_wdata, 2)));
endmodule

bind wt_cache4 wtc_checker #(.OFS_W(OFS_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_we    (cpu_req_we),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_rsp_valid (cpu_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata)
);

// File: tb/wt_cache4_tb.sv
module wt_cache4_tb;
    localparam int NSETS = 128;
    localparam int NWAYS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
    logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
    logic cpu_req_ready, cpu_rsp_valid;
    logic [31:0] cpu_rsp_rdata;
    logic mem_req_valid, mem_req_we;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    always #2.5 clk = ~clk;

    wt_cache4 u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    int n_tests = 0, n_fail = 0, n_hits = 0, n_misses = 0;

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // ---------------- reference memory ----------------
    logic [31:0] mem_m [logic [31:0]];
    function automatic logic [31:0] seed_word(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction
    function automatic logic [31:0] mem_rd(logic [31:0] a);
        logic [31:0] wa = {a[31:2], 2'b00};
        return mem_m.exists(wa) ? mem_m[wa] : seed_word(wa);
    endfunction

    int fill_cnt = 0, wr_cnt = 0;
    logic [31:0] last_fill_addr = '0, last_wr_addr = '0, last_wr_data = '0;

    // Memory responder: acts just after each rising edge.
    initial begin : mem_model
        int beat = 0, stall = 0, gap = 0;
        bit pend = 0;
        logic [31:0] base = '0;
        forever begin
            @(posedge clk); #1;
            if (rst) begin
                pend = 0; beat = 0;
                mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
                continue;
            end
            if (mem_rsp_valid) begin
                beat++;
                if (beat == 4) pend = 0;
            end
            gap++;
            mem_rsp_valid = pend && (gap % 5 != 2);
            mem_rsp_rdata = mem_rd(base + 32'(beat * 4));
            stall++;
            mem_req_ready = (stall % 3 != 0);
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    wr_cnt++;
                    last_wr_addr = mem_req_addr;
                    last_wr_data = mem_req_wdata;
                    mem_m[{mem_req_addr[31:2], 2'b00}] = mem_req_wdata;
                end else begin
                    fill_cnt++;
                    last_fill_addr = mem_req_addr;
                    base = mem_req_addr;
                    pend = 1; beat = 0;
                end
            end
        end
    end

    // ---------------- reference cache (per-set recency queues) ----------------
    int unsigned m_tag [NSETS][NWAYS];
    bit          m_vld [NSETS][NWAYS];
    int unsigned m_q   [NSETS][$];   // front = least recently used

    function automatic int m_find(logic [31:0] a);
        int s = int'(a[10:4]);
        int unsigned t = int'(a[31:11]);
        for (int w = 0; w < NWAYS; w++)
            if (m_vld[s][w] && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic void m_touch(int s, int w);
        for (int i = 0; i < m_q[s].size(); i++) begin
            if (m_q[s][i] == w) begin
                m_q[s].delete(i);
                break;
            end
        end
        m_q[s].push_back(w);
    endfunction

    function automatic void m_fill(logic [31:0] a);
        int s = int'(a[10:4]);
        int v = -1;
        for (int w = 0; w < NWAYS; w++)
            if (!m_vld[s][w] && v < 0) v = w;
        if (v < 0) v = int'(m_q[s][0]);
        m_vld[s][v] = 1'b1;
        m_tag[s][v] = int'(a[31:11]);
        m_touch(s, v);
    endfunction

    // ---------------- CPU-side transaction ----------------
    task automatic cpu_op(input bit we, input logic [31:0] addr, input logic [31:0] wd, input string rq);
        int f0, w0, cyc, hw;
        logic [31:0] got, exp;
        hw = m_find(addr);
        f0 = fill_cnt; w0 = wr_cnt;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = addr; cpu_req_wdata = wd;
        while (!cpu_req_ready) @(negedge clk);
        @(posedge clk); #1;
        cpu_req_valid = 1'b0;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_rsp_valid && cyc < 300);
        got = cpu_rsp_rdata;
        if (hw >= 0) n_hits++; else n_misses++;
        if (we) begin
            check(wr_cnt - w0 == 1, {rq, " R4 one memory write"}, 32'(wr_cnt - w0), 1);
            check(last_wr_addr == addr, {rq, " R4 write address"}, last_wr_addr, addr);
            check(last_wr_data == wd, {rq, " R4 write data"}, last_wr_data, wd);
            check(fill_cnt == f0, {rq, " R6 write fetches no line"}, 32'(fill_cnt - f0), 0);
            if (hw >= 0) m_touch(int'(addr[10:4]), hw);
        end else begin
            exp = mem_rd(addr);
            check(got == exp, {rq, " read data"}, got, exp);
            check((fill_cnt - f0) == ((hw >= 0) ? 0 : 1), {rq, " hit/miss"},
                  32'(fill_cnt - f0), (hw >= 0) ? 0 : 1);
            if (hw >= 0) begin
                check(cyc == 1, {rq, " R2 hit latency"}, 32'(cyc), 1);
                m_touch(int'(addr[10:4]), hw);
            end else begin
                check(last_fill_addr == {addr[31:4], 4'h0}, {rq, " R3 line address"},
                      last_fill_addr, {addr[31:4], 4'h0});
                m_fill(addr);
            end
        end
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < NWAYS; w++) m_vld[s][w] = 1'b0;
    endtask

    function automatic logic [31:0] mk(int tag, int set, int word);
        return (32'(tag) << 11) | (32'(set) << 4) | (32'(word) << 2);
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] a, b, lfsr;
        for (int s = 0; s < NSETS; s++) begin
            for (int w = NWAYS - 1; w >= 0; w--) m_q[s].push_back(w);
            for (int w = 0; w < NWAYS; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = 0; end
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cpu_req_ready == 1'b1, "R11 ready after reset", 32'(cpu_req_ready), 1);
        check(mem_req_valid == 1'b0, "R11 no memory request", 32'(mem_req_valid), 0);
        check(cpu_rsp_valid == 1'b0, "R11 no response", 32'(cpu_rsp_valid), 0);

        // Read miss then hits on the same line
        a = 32'h0000_1230;
        cpu_op(0, a, 0, "R11 R3 first read misses");
        for (int k = 1; k < 4; k++) cpu_op(0, a + 32'(4 * k), 0, "R3 R2 line words hit");
        cpu_op(0, a, 0, "R2 repeat hit");

        // Write hit then read back
        cpu_op(1, a + 4, 32'hCAFE_0001, "R5 write hit");
        cpu_op(0, a + 4, 0, "R5 read after write hit");

        // Write miss does not allocate
        b = 32'h0000_4560;
        cpu_op(1, b, 32'hBEEF_0002, "R6 write miss");
        cpu_op(0, b, 0, "R6 read after write miss");

        // Same set, different tag; different set
        cpu_op(0, a + 32'd2048, 0, "R1 same set other tag");
        cpu_op(0, a + 32'd16, 0, "R1 next set");
        cpu_op(0, a, 0, "R1 original still resident");

        // Invalid-first refill after flush, then LRU eviction
        do_flush();
        for (int t = 0; t < 4; t++) cpu_op(0, mk(t + 8, 4, 0), 0, "R9 R7 fill after flush");
        for (int t = 0; t < 4; t++) cpu_op(0, mk(t + 8, 4, 1), 0, "R7 all four resident");
        cpu_op(0, mk(8, 4, 2), 0, "R8 touch oldest");
        cpu_op(0, mk(12, 4, 0), 0, "R8 fifth tag evicts");
        cpu_op(0, mk(8, 4, 0), 0, "R8 touched line kept");
        cpu_op(0, mk(10, 4, 0), 0, "R8 younger line kept");
        cpu_op(1, mk(11, 4, 3), 32'h1111_2222, "R8 write hit counts as use");
        cpu_op(0, mk(9, 4, 0), 0, "R8 evicted line misses");
        cpu_op(0, mk(11, 4, 3), 0, "R8 written line kept");

        // Pseudo-random mix on three sets, six tags
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 400; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            a = mk(int'(lfsr[10:8]) % 6, int'(lfsr[13:12]) % 3 + 20, int'(lfsr[3:2]));
            if (lfsr[20:19] == 2'b00) cpu_op(1, a, lfsr ^ 32'h00FF_FF00, "R8 random write");
            else                      cpu_op(0, a, 0, "R8 random read");
            if (i == 200) do_flush();
        end

        // Flush makes everything miss
        cpu_op(0, mk(0, 20, 0), 0, "R9 warm line");
        do_flush();
        cpu_op(0, mk(0, 20, 0), 0, "R9 miss after flush");

        $display("  hits=%0d misses=%0d", n_hits, n_misses);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule